// File: doc/BRIEF.md
# MII Management Host Read Engine

This block lets software read registers in external Ethernet PHY devices over the two-wire management bus. Software loads a 5-bit PHY address and a 5-bit register number and sets one of two read command bits in the same write. The engine then serializes a management read frame, generates the management clock from the system clock with a programmable divider, releases the data line for turnaround, and shifts in the 16-bit reply. When the frame ends it sets a done flag, places the reply in the data field, and raises a command-complete interrupt flag. If the PHY does not pull the line low during turnaround, a separate read-error flag is raised as well.

The management bus is shared with a background register poller through a simple arbiter. While the poller requests the bus, its clock and data signals drive the pins and a host frame waits. Once a host frame has started, it keeps the bus to the end. Because a host frame can be delayed this way, software must treat the done flag as the only sign of completion. Each access can drop the 32-bit preamble. An access issued through the legacy path always sends the preamble.

Top module: `mdio_host_engine`

## Requirements
- R1: A write with exactly one of the two read bits set, made while the engine is idle, starts a frame. After any preamble the frame drives, MSB first, the start bits 0,1, the read opcode 1,0, the 5-bit PHY address and the 5-bit register number.
- R2: A write with both read bits set is ignored. No management clock edge follows, and the done flag, data field and interrupt flags keep their values.
- R3: The done flag reads 0 one cycle after a command is accepted. At the end of the frame it reads 1, the data field holds the 16 bits sampled MSB first, and the command-complete flag is set.
- R4: The line is sampled on the second turnaround bit. If it reads 1, the read-error flag is set. The irq output equals (complete flag AND its enable) OR (error flag AND its enable). Each flag clears on its own clear input.
- R5: With the suppress bit at 0 the frame begins with 32 driven ones. With it at 1 the frame begins directly with the start bits.
- R6: A command marked legacy always sends the 32-bit preamble, whatever the suppress bit holds.
- R7: The management clock is low when idle and has a period of 2*HALF_DIV system clocks during a frame. The data output changes only while the clock is low. The output enable is 0 for the turnaround bits and the 16 reply bits.
- R8: For a blocking read, hostStall is 1 from the cycle after acceptance until the frame ends. A non-blocking read never raises it.
- R9: A command written while an access is pending or running is ignored. The running frame keeps its address, and no second frame follows.
- R10: While pollReq is 1 and no host frame is running, pollGnt is 1, the pins follow the poller's signals, and a pending host frame does not start. During a host frame pollGnt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command register write strobe |
| wrPhyAddr | input | 5 | PHY address field |
| wrRegAddr | input | 5 | PHY register number field |
| wrBlkRd | input | 1 | Blocking read command bit |
| wrNblkRd | input | 1 | Non-blocking read command bit |
| wrPreSup | input | 1 | Drop the preamble for this access |
| wrLegacy | input | 1 | Access comes from the legacy path (preamble forced) |
| enCcIrq | input | 1 | Enable for the command-complete interrupt |
| enReIrq | input | 1 | Enable for the read-error interrupt |
| clrCc | input | 1 | Clear the command-complete flag |
| clrRe | input | 1 | Clear the read-error flag |
| mdioIn | input | 1 | Management data line input |
| pollReq | input | 1 | Background poller bus request |
| pollMdc | input | 1 | Poller management clock |
| pollMdo | input | 1 | Poller data output |
| pollMdoEn | input | 1 | Poller data output enable |
| pollGnt | output | 1 | Bus granted to the poller |
| mdc | output | 1 | Management clock pin |
| mdoOut | output | 1 | Management data output |
| mdoEn | output | 1 | Management data output enable |
| cmdDone | output | 1 | Done flag of the command register |
| rdData | output | 16 | Data field of the command register |
| intCc | output | 1 | Command-complete interrupt flag |
| intRe | output | 1 | Read-error interrupt flag |
| irq | output | 1 | Interrupt request |
| hostStall | output | 1 | Host held while a blocking read runs |

## Verification
On every cycle, the assertions check four things: the data output stays still while the management clock is high, the clock drops when no frame runs, the poller is never granted during a host frame, and an illegal or busy-time write leaves the engine and its latched address untouched. The bench scenarios cover the rest. They decode the preamble length, header fields and clock period as seen on the pins, return chosen reply words and turnaround faults from a PHY model, and show the interaction between the interrupt flags and enables. They also confirm that ignored writes and bus sharing produce no stray frames.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 14;
  localparam int TA_BITS    = 2;
  localparam int DATA_BITS  = 16;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int HDR_LAST   = PRE_BITS + HDR_BITS - 1;
  localparam int TA2_IDX    = HDR_LAST + TA_BITS;
  localparam int DATA_FIRST = TA2_IDX + 1;
  localparam int LAST_IDX   = FRAME_BITS - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} engState_t;

  typedef struct packed {
    logic             load;
    logic             runClk;
    logic             busy;
    logic             sampleTa;
    logic             sampleData;
    logic             finish;
    logic [IDX_W-1:0] bitIdx;
  } ctlStrobe_t;

  typedef struct packed {
    logic riseEv;
    logic fallEv;
  } dpEvent_t;
endpackage

// File: rtl/mdio_host_ctl.sv
module mdio_host_ctl
  import mdio_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       wrBlkRd,
  input  logic       wrNblkRd,
  input  logic       wrPreSup,
  input  logic       wrLegacy,
  input  logic       pollReq,
  input  dpEvent_t   ev,
  output ctlStrobe_t ctl,
  output logic       pollGnt,
  output logic       hostStall
);
  engState_t        state;
  logic [IDX_W-1:0] bitIdx;
  logic             blkQ;
  logic             accept;
  logic             lastBit;

  assign accept  = (state == ST_IDLE) && cmdWr && (wrBlkRd ^ wrNblkRd);
  assign lastBit = (bitIdx == IDX_W'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitIdx <= '0;
      blkQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_WAIT;
          bitIdx <= (wrPreSup && !wrLegacy) ? IDX_W'(PRE_BITS) : '0;
          blkQ   <= wrBlkRd;
        end
        ST_WAIT: if (!pollReq) state <= ST_RUN;
        ST_RUN: if (ev.fallEv) begin
          if (lastBit) state <= ST_IDLE;
          else         bitIdx <= bitIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = accept;
    ctl.runClk     = (state == ST_RUN);
    ctl.busy       = (state != ST_IDLE);
    ctl.bitIdx     = bitIdx;
    ctl.sampleTa   = ctl.runClk && ev.riseEv && (bitIdx == IDX_W'(TA2_IDX));
    ctl.sampleData = ctl.runClk && ev.riseEv && (bitIdx >= IDX_W'(DATA_FIRST));
    ctl.finish     = ctl.runClk && ev.fallEv && lastBit;
  end

  assign pollGnt   = pollReq && (state != ST_RUN);
  assign hostStall = blkQ && (state != ST_IDLE);

  p_both_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdWr && wrBlkRd && wrNblkRd) |=> (state == ST_IDLE));
  p_no_grant_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> !pollGnt);
  p_busy_state_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cmdWr && pollReq) |=> (state == ST_WAIT));
  p_stall_origin_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostStall) |-> $past(cmdWr && wrBlkRd && !wrNblkRd));
endmodule

// File: rtl/mdio_host_dp.sv
module mdio_host_dp
  import mdio_host_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  ctl,
  input  logic [4:0]  wrPhyAddr,
  input  logic [4:0]  wrRegAddr,
  input  logic        enCcIrq,
  input  logic        enReIrq,
  input  logic        clrCc,
  input  logic        clrRe,
  input  logic        mdioIn,
  output dpEvent_t    ev,
  output logic        mdcEng,
  output logic        mdoEng,
  output logic        mdoEnEng,
  output logic        cmdDone,
  output logic [15:0] rdData,
  output logic        intCc,
  output logic        intRe,
  output logic        irq
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam int HI_W  = $clog2(HDR_BITS);

  logic [CNT_W-1:0]     divCnt;
  logic                 mdcQ;
  logic                 terminal;
  logic [9:0]           hdrQ;
  logic [HDR_BITS-1:0]  hdrFull;
  logic [HI_W-1:0]      hdrSel;
  logic [DATA_BITS-1:0] shiftQ;
  logic                 taErrQ;
  logic                 doneQ;
  logic [DATA_BITS-1:0] dataQ;
  logic                 ccQ;
  logic                 reQ;

  assign terminal  = (divCnt == CNT_W'(HALF_DIV - 1));
  assign ev.riseEv = ctl.runClk && terminal && !mdcQ;
  assign ev.fallEv = ctl.runClk && terminal && mdcQ;

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.runClk) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (terminal) begin
      divCnt <= '0;
      mdcQ   <= !mdcQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign hdrFull = {4'b0110, hdrQ};
  assign hdrSel  = HI_W'(HDR_LAST - int'(ctl.bitIdx));

  always_comb begin
    mdoEnEng = ctl.runClk && (ctl.bitIdx <= IDX_W'(HDR_LAST));
    if (!mdoEnEng)                             mdoEng = 1'b0;
    else if (ctl.bitIdx < IDX_W'(PRE_BITS))    mdoEng = 1'b1;
    else                                       mdoEng = hdrFull[hdrSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ   <= '0;
      shiftQ <= '0;
      taErrQ <= 1'b0;
      doneQ  <= 1'b0;
      dataQ  <= '0;
      ccQ    <= 1'b0;
      reQ    <= 1'b0;
    end else begin
      if (ctl.load) begin
        hdrQ   <= {wrPhyAddr, wrRegAddr};
        taErrQ <= 1'b0;
        doneQ  <= 1'b0;
      end
      if (ctl.sampleTa)   taErrQ <= mdioIn;
      if (ctl.sampleData) shiftQ <= {shiftQ[DATA_BITS-2:0], mdioIn};
      if (ctl.finish) begin
        doneQ <= 1'b1;
        dataQ <= shiftQ;
      end
      if (ctl.finish)   ccQ <= 1'b1;
      else if (clrCc)   ccQ <= 1'b0;
      if (ctl.finish && taErrQ) reQ <= 1'b1;
      else if (clrRe)           reQ <= 1'b0;
    end
  end

  assign mdcEng  = mdcQ;
  assign cmdDone = doneQ;
  assign rdData  = dataQ;
  assign intCc   = ccQ;
  assign intRe   = reQ;
  assign irq     = (ccQ && enCcIrq) || (reQ && enReIrq);

  p_mdo_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runClk && $past(ctl.runClk) && mdcQ && $past(mdcQ)) |-> $stable(mdoEng));
  p_idle_mdc_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.runClk |=> !mdcQ);
  p_done_with_cc_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> ccQ);
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !ctl.load) |=> $stable(hdrQ));
endmodule

// File: rtl/mdio_host_engine.sv
module mdio_host_engine
  import mdio_host_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [4:0]  wrPhyAddr,
  input  logic [4:0]  wrRegAddr,
  input  logic        wrBlkRd,
  input  logic        wrNblkRd,
  input  logic        wrPreSup,
  input  logic        wrLegacy,
  input  logic        enCcIrq,
  input  logic        enReIrq,
  input  logic        clrCc,
  input  logic        clrRe,
  input  logic        mdioIn,
  input  logic        pollReq,
  input  logic        pollMdc,
  input  logic        pollMdo,
  input  logic        pollMdoEn,
  output logic        pollGnt,
  output logic        mdc,
  output logic        mdoOut,
  output logic        mdoEn,
  output logic        cmdDone,
  output logic [15:0] rdData,
  output logic        intCc,
  output logic        intRe,
  output logic        irq,
  output logic        hostStall
);
  ctlStrobe_t ctl;
  dpEvent_t   ev;
  logic       mdcEng;
  logic       mdoEng;
  logic       mdoEnEng;

  mdio_host_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .wrBlkRd(wrBlkRd), .wrNblkRd(wrNblkRd),
    .wrPreSup(wrPreSup), .wrLegacy(wrLegacy), .pollReq(pollReq), .ev(ev),
    .ctl(ctl), .pollGnt(pollGnt), .hostStall(hostStall)
  );

  mdio_host_dp #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrPhyAddr(wrPhyAddr), .wrRegAddr(wrRegAddr),
    .enCcIrq(enCcIrq), .enReIrq(enReIrq), .clrCc(clrCc), .clrRe(clrRe), .mdioIn(mdioIn),
    .ev(ev), .mdcEng(mdcEng), .mdoEng(mdoEng), .mdoEnEng(mdoEnEng), .cmdDone(cmdDone),
    .rdData(rdData), .intCc(intCc), .intRe(intRe), .irq(irq)
  );

  assign mdc    = pollGnt ? pollMdc   : mdcEng;
  assign mdoOut = pollGnt ? pollMdo   : mdoEng;
  assign mdoEn  = pollGnt ? pollMdoEn : mdoEnEng;
endmodule

// File: tb/sim_mdio_host_engine.sv
`timescale 1ns/1ps
module sim_mdio_host_engine;
  localparam int HALF_DIV = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWr = 0, wrBlkRd = 0, wrNblkRd = 0, wrPreSup = 0, wrLegacy = 0;
  logic [4:0] wrPhyAddr = '0, wrRegAddr = '0;
  logic enCcIrq = 0, enReIrq = 0, clrCc = 0, clrRe = 0;
  logic mdioIn = 1'b1;
  logic pollReq = 0, pollMdc = 0, pollMdo = 0, pollMdoEn = 0;
  logic pollGnt, mdc, mdoOut, mdoEn, cmdDone, intCc, intRe, irq, hostStall;
  logic [15:0] rdData;

  int checks = 0, fails = 0;
  bit finished = 0;
  longint cyc = 0;

  // PHY model state
  int preCnt = 0, hdrCnt = 0, phase = 0, drvPos = 0, mdcRises = 0;
  longint lastRise = 0, period = 0;
  logic [13:0] hdrBits = '0;
  logic [15:0] phyData = 16'h0000;
  bit errMode = 0;
  bit stallSeen = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_host_engine #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .wrPhyAddr(wrPhyAddr), .wrRegAddr(wrRegAddr),
    .wrBlkRd(wrBlkRd), .wrNblkRd(wrNblkRd), .wrPreSup(wrPreSup), .wrLegacy(wrLegacy),
    .enCcIrq(enCcIrq), .enReIrq(enReIrq), .clrCc(clrCc), .clrRe(clrRe), .mdioIn(mdioIn),
    .pollReq(pollReq), .pollMdc(pollMdc), .pollMdo(pollMdo), .pollMdoEn(pollMdoEn),
    .pollGnt(pollGnt), .mdc(mdc), .mdoOut(mdoOut), .mdoEn(mdoEn), .cmdDone(cmdDone),
    .rdData(rdData), .intCc(intCc), .intRe(intRe), .irq(irq), .hostStall(hostStall)
  );

  always @(posedge mdc) begin
    mdcRises++;
    period = cyc - lastRise;
    lastRise = cyc;
    if (phase == 0) begin
      if (mdoEn) begin
        if (mdoOut) preCnt++;
        else begin hdrBits = '0; hdrCnt = 1; phase = 1; end
      end
    end else if (phase == 1) begin
      hdrBits = {hdrBits[12:0], mdoOut};
      hdrCnt++;
      if (hdrCnt == 14) begin phase = 2; drvPos = 0; end
    end
  end

  always @(negedge mdc) begin
    if (phase == 2) begin
      if (drvPos == 0)       mdioIn = 1'b1;
      else if (drvPos == 1)  mdioIn = errMode;
      else if (drvPos < 18)  mdioIn = phyData[17 - drvPos];
      else begin mdioIn = 1'b1; phase = 0; end
      drvPos++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input [4:0] pa, input [4:0] ra, input bit blk, input bit nblk,
                       input bit sup, input bit leg);
    @(negedge clk);
    wrPhyAddr = pa; wrRegAddr = ra; wrBlkRd = blk; wrNblkRd = nblk;
    wrPreSup = sup; wrLegacy = leg; cmdWr = 1;
    @(negedge clk);
    cmdWr = 0; wrBlkRd = 0; wrNblkRd = 0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (cmdDone) begin ok = 1; break; end
      if (hostStall) stallSeen = 1;
      @(negedge clk);
    end
  endtask

  task automatic clearFlags();
    @(negedge clk); clrCc = 1; clrRe = 1;
    @(negedge clk); clrCc = 0; clrRe = 0;
  endtask

  task automatic testReset();
    check(cmdDone == 0, "R3 reset done", cmdDone, 0);
    check(mdc == 0 && mdoEn == 0, "R7 reset idle bus", {mdc, mdoEn}, 0);
    check(irq == 0 && intCc == 0 && intRe == 0, "R4 reset flags", {irq, intCc, intRe}, 0);
  endtask

  task automatic testPlainRead();
    bit ok;
    preCnt = 0; phyData = 16'hA53C; errMode = 0;
    issue(5'd17, 5'd6, 0, 1, 0, 0);
    check(cmdDone == 0, "R3 done clears on accept", cmdDone, 0);
    waitDone(ok);
    check(ok, "R3 frame completes", ok, 1);
    check(rdData == 16'hA53C, "R3 data field", rdData, 16'hA53C);
    check(intCc == 1 && intRe == 0, "R3 complete flag", {intCc, intRe}, 2'b10);
    check(preCnt == 32, "R5 full preamble", preCnt, 32);
    check(hdrBits == {4'b0110, 5'd17, 5'd6}, "R1 header bits", hdrBits, {4'b0110, 5'd17, 5'd6});
    check(period == 2 * HALF_DIV, "R7 mdc period", period, 2 * HALF_DIV);
    check(!stallSeen, "R8 no stall on nonblocking", stallSeen, 0);
    clearFlags();
  endtask

  task automatic testSuppress();
    bit ok;
    preCnt = 0; phyData = 16'h0F81;
    issue(5'd3, 5'd31, 0, 1, 1, 0);
    waitDone(ok);
    check(ok && preCnt == 0, "R5 preamble suppressed", preCnt, 0);
    check(rdData == 16'h0F81, "R3 data after suppressed frame", rdData, 16'h0F81);
    check(hdrBits == {4'b0110, 5'd3, 5'd31}, "R1 header no preamble", hdrBits, {4'b0110, 5'd3, 5'd31});
    clearFlags();
  endtask

  task automatic testLegacy();
    bit ok;
    preCnt = 0; phyData = 16'h1234;
    issue(5'd1, 5'd1, 0, 1, 1, 1);
    waitDone(ok);
    check(ok && preCnt == 32, "R6 legacy forces preamble", preCnt, 32);
    clearFlags();
  endtask

  task automatic testBothBits();
    int rises;
    logic [15:0] d;
    d = rdData; rises = mdcRises;
    issue(5'd9, 5'd9, 1, 1, 0, 0);
    repeat (300) @(negedge clk);
    check(mdcRises == rises, "R2 no frame on both bits", mdcRises, rises);
    check(cmdDone == 1 && rdData == d, "R2 done and data kept", {cmdDone, rdData}, {1'b1, d});
    check(intCc == 0 && intRe == 0, "R2 flags untouched", {intCc, intRe}, 0);
  endtask

  task automatic testBlocking();
    bit ok;
    phyData = 16'hBEEF;
    issue(5'd4, 5'd2, 1, 0, 0, 0);
    check(hostStall == 1, "R8 stall after accept", hostStall, 1);
    waitDone(ok);
    check(ok && hostStall == 0, "R8 stall drops at end", hostStall, 0);
    check(rdData == 16'hBEEF, "R3 blocking data", rdData, 16'hBEEF);
    clearFlags();
  endtask

  task automatic testError();
    bit ok;
    phyData = 16'h5555; errMode = 1;
    issue(5'd8, 5'd8, 0, 1, 0, 0);
    waitDone(ok);
    errMode = 0;
    @(negedge clk);
    check(intRe == 1 && intCc == 1, "R4 read error flag", {intCc, intRe}, 2'b11);
    check(irq == 0, "R4 irq masked", irq, 0);
    enReIrq = 1; @(negedge clk);
    check(irq == 1, "R4 irq from error enable", irq, 1);
    clrRe = 1; @(negedge clk); clrRe = 0; @(negedge clk);
    check(intRe == 0 && irq == 0 && intCc == 1, "R4 error clear", {intCc, intRe, irq}, 3'b100);
    enReIrq = 0; enCcIrq = 1; @(negedge clk);
    check(irq == 1, "R4 irq from complete enable", irq, 1);
    enCcIrq = 0;
    clearFlags();
  endtask

  task automatic testBusyWrite();
    bit ok;
    int rises;
    phyData = 16'h7E01;
    issue(5'd2, 5'd3, 0, 1, 0, 0);
    repeat (50) @(negedge clk);
    issue(5'd12, 5'd9, 0, 1, 0, 0);
    waitDone(ok);
    check(ok && hdrBits == {4'b0110, 5'd2, 5'd3}, "R9 busy write ignored", hdrBits, {4'b0110, 5'd2, 5'd3});
    rises = mdcRises;
    repeat (300) @(negedge clk);
    check(mdcRises == rises && cmdDone == 1, "R9 no second frame", mdcRises, rises);
    clearFlags();
  endtask

  task automatic testPoller();
    bit ok;
    int rises;
    phyData = 16'hC3A5;
    @(negedge clk); pollReq = 1; pollMdoEn = 1; pollMdo = 1;
    @(negedge clk);
    check(pollGnt == 1 && mdoEn == 1 && mdoOut == 1, "R10 poller owns pins", {pollGnt, mdoEn, mdoOut}, 3'b111);
    rises = mdcRises;
    issue(5'd5, 5'd5, 0, 1, 0, 0);
    repeat (100) @(negedge clk);
    check(mdcRises == rises && cmdDone == 0, "R10 host frame waits", mdcRises, rises);
    pollMdoEn = 0; pollMdo = 0; pollReq = 0;
    repeat (20) @(negedge clk);
    pollReq = 1; @(negedge clk);
    check(pollGnt == 0, "R10 no grant during host frame", pollGnt, 0);
    pollReq = 0;
    waitDone(ok);
    check(ok && rdData == 16'hC3A5, "R10 host frame after poller", rdData, 16'hC3A5);
    clearFlags();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPlainRead();
    testSuppress();
    testLegacy();
    testBothBits();
    testBlocking();
    testError();
    testBusyWrite();
    testPoller();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule